// File: doc/BRIEF.md
# Sum-Addressed Wordline Decoder

This block drives the wordlines of a memory or cache array straight from two address operands, a base and an offset. It never adds them with a carry-propagate adder. Instead each wordline checks whether the base plus the offset equals its own row number. The check uses carry-save logic that is specialised to that row's constant. The per-bit terms for this check are computed once and shared by all rows. Each row then only picks one of four shared wires per bit and ANDs its picks together. This takes the adder delay off the path from address to wordline.

The operands are `OP_W = LO_BIT + IDX_W + 1` bits wide, which is 14 bits by default. Only the field from bit `LO_BIT` (3) up to the top bit is used. The row number is that field of base plus offset, shifted right by one, so with the defaults it is bits 13..4 of the sum. Carries from below bit `LO_BIT` are not included: the bits under `LO_BIT` are a byte offset that the array ignores. The carry out of the top bit is dropped, so the sum wraps around.

An optional output register (`REG_OUT`, on by default) holds the wordlines for one clock cycle and clears them under an asynchronous active-low reset. With `REG_OUT = 0` the block is purely combinational, and the clock and reset pins have no effect.

Top module: `sad_decoder`

## Requirements
- R1: With `REG_OUT=1`, one clock edge after the operands are sampled, `wl` has exactly bit k set, where k = ((op_a[13:3] + op_b[13:3]) >> 1) mod 1024.
- R2: For every operand pair, exactly one wordline is asserted once reset is released.
- R3: Changing op_a[2:0] or op_b[2:0] never changes the selected wordline.
- R4: A sum at or above 2^14 wraps, for example 0x3FF8 + 0x0008 selects row 0.
- R5: A carry produced at bit 3 (op_a[3] = op_b[3] = 1) reaches the row index, for example 0x0008 + 0x0008 selects row 1 while 0x0008 + 0x0000 selects row 0.
- R6: While rst_n is low, the registered `wl` is all zeros.
- R7: With `REG_OUT=0`, `wl` shows the row from R1 for the present operands, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_a | input | OP_W (14) | Base operand |
| op_b | input | OP_W (14) | Offset operand |
| wl | output | 2^IDX_W (1024) | One-hot wordlines |

## Verification
Every value of the base field is swept against a handful of offsets: zero, the smallest step at bit 3, a mid value, and all ones. These tell apart a wrong row constant, a wrong carry term at the lowest compared bit, and a missing wrap. Pseudo-random pairs whose bits 2..0 are scrambled show that the low bits are ignored. Short directed pairs pin down the bit-3 carry and the modulo wrap. A registered and a combinational instance are checked side by side, along with the cleared state under reset.

// File: rtl/sad_pkg.sv
package sad_pkg;

    // Four shared comparison wires of one bit position, named by
    // (row constant at this bit, row constant at the bit below)
    typedef struct packed {
        logic l0p0;
        logic l0p1;
        logic l1p0;
        logic l1p1;
    } sad_term_t;

    // Pick the wire that matches a row's constant pair
    function automatic logic sad_pick(input sad_term_t t, input logic l_cur, input logic l_prev);
        logic r;
        unique case ({l_cur, l_prev})
            2'b00:   r = t.l0p0;
            2'b01:   r = t.l0p1;
            2'b10:   r = t.l1p0;
            default: r = t.l1p1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sad_terms.sv
module sad_terms
    import sad_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic [IDX_W:0] fa,    // operand field, lowest element is the dropped sum bit
    input  logic [IDX_W:0] fb,
    output sad_term_t      terms [IDX_W]
);

    for (genvar j = 0; j < IDX_W; j++) begin : g_bit
        logic half_sum;   // sum bit with a zero constant
        logic cy_and;     // carry from the bit below, its constant zero
        logic cy_or;      // carry from the bit below, its constant one

        assign half_sum = fa[j+1] ^ fb[j+1];
        assign cy_and   = fa[j] & fb[j];
        assign cy_or    = fa[j] | fb[j];

        assign terms[j].l0p0 = half_sum ^ cy_and;
        assign terms[j].l0p1 = half_sum ^ cy_or;
        assign terms[j].l1p0 = ~(half_sum ^ cy_and);
        assign terms[j].l1p1 = ~(half_sum ^ cy_or);
    end

endmodule

// File: rtl/sad_row.sv
module sad_row
    import sad_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int ROW   = 0
) (
    input  sad_term_t terms [IDX_W],
    output logic      hit
);

    // Row constant is the complement of the row number; the bit under
    // the compared field carries a zero constant
    localparam logic [IDX_W-1:0] ROW_BITS = ROW[IDX_W-1:0];
    localparam logic [IDX_W:0]   L_VEC    = {~ROW_BITS, 1'b0};

    logic [IDX_W-1:0] picks;

    always_comb begin
        for (int j = 0; j < IDX_W; j++) begin
            picks[j] = sad_pick(terms[j], L_VEC[j+1], L_VEC[j]);
        end
    end

    assign hit = &picks;

endmodule

// File: rtl/sad_out_stage.sv
module sad_out_stage #(
    parameter int W       = 1024,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
        end
    end else begin : g_pass
        logic unused_ctl;
        assign unused_ctl = clk ^ rst_n;
        assign q = d;
    end

endmodule

// File: rtl/sad_decoder.sv
module sad_decoder
    import sad_pkg::*;
#(
    parameter int LO_BIT  = 3,
    parameter int IDX_W   = 10,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [LO_BIT+IDX_W:0]          op_a,
    input  logic [LO_BIT+IDX_W:0]          op_b,
    output logic [(1<<IDX_W)-1:0]          wl
);

    localparam int OP_W = LO_BIT + IDX_W + 1;
    localparam int ROWS = 1 << IDX_W;

    sad_term_t        terms [IDX_W];
    logic [ROWS-1:0]  row_hit;
    logic             unused_low;

    assign unused_low = ^{op_a[LO_BIT-1:0], op_b[LO_BIT-1:0]};

    sad_terms #(.IDX_W(IDX_W)) u_terms (
        .fa    (op_a[OP_W-1:LO_BIT]),
        .fb    (op_b[OP_W-1:LO_BIT]),
        .terms (terms)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        sad_row #(.IDX_W(IDX_W), .ROW(r)) u_row (
            .terms (terms),
            .hit   (row_hit[r])
        );
    end

    sad_out_stage #(.W(ROWS), .REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (row_hit),
        .q     (wl)
    );

endmodule

// File: rtl/sad_decoder_chk.sv
module sad_decoder_chk #(
    parameter int LO_BIT  = 3,
    parameter int IDX_W   = 10,
    parameter bit REG_OUT = 1'b1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [IDX_W:0]        fa,
    input logic [IDX_W:0]        fb,
    input logic [(1<<IDX_W)-1:0] row_hit,
    input logic [(1<<IDX_W)-1:0] wl
);

    localparam int ROWS = 1 << IDX_W;

    logic [IDX_W:0]   full_sum;
    logic [IDX_W-1:0] ref_idx;
    logic             armed;

    assign full_sum = fa + fb;
    assign ref_idx  = full_sum[IDX_W:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2: the shared-term decode is one-hot
    p_comb_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(row_hit) == 1);

    // R1 / R7: decoded row agrees with a plain adder
    p_comb_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
        row_hit == (ROWS'(1) << ref_idx));

    if (REG_OUT) begin : g_reg_chk
        p_row_index_r1: assert property (@(posedge clk) disable iff (!rst_n)
            armed |-> wl == (ROWS'(1) << $past(ref_idx)));

        p_low_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
            armed && $stable(fa) && $stable(fb) |=> $stable(wl));

        always @(posedge clk) begin
            if (!rst_n) begin
                p_reset_clear_r6: assert (wl == '0);
            end
        end
    end

endmodule

bind sad_decoder sad_decoder_chk #(
    .LO_BIT  (LO_BIT),
    .IDX_W   (IDX_W),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .fa      (op_a[OP_W-1:LO_BIT]),
    .fb      (op_b[OP_W-1:LO_BIT]),
    .row_hit (row_hit),
    .wl      (wl)
);

// File: tb/sim_sad_decoder.sv
`timescale 1ns/1ps
module sim_sad_decoder;

    localparam int LO_BIT = 3;
    localparam int IDX_W  = 10;
    localparam int OP_W   = LO_BIT + IDX_W + 1;
    localparam int ROWS   = 1 << IDX_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [OP_W-1:0] op_a = '0;
    logic [OP_W-1:0] op_b = '0;
    logic [ROWS-1:0] wl_reg;
    logic [ROWS-1:0] wl_cmb;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sad_decoder #(.LO_BIT(LO_BIT), .IDX_W(IDX_W), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .wl(wl_reg));

    sad_decoder #(.LO_BIT(LO_BIT), .IDX_W(IDX_W), .REG_OUT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .wl(wl_cmb));

    function automatic int exp_row(input int a, input int b);
        return (((a >> LO_BIT) + (b >> LO_BIT)) >> 1) & (ROWS - 1);
    endfunction

    function automatic int first_row(input logic [ROWS-1:0] v);
        for (int i = 0; i < ROWS; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic check_vec(input string req, input logic [ROWS-1:0] got, input int exp);
        checks++;
        if (got !== (ROWS'(1) << exp)) begin
            errors++;
            $display("FAIL %s a=%h b=%h got_row=%0d ones=%0d exp_row=%0d",
                     req, op_a, op_b, first_row(got), $countones(got), exp);
        end
    endtask

    // drive at a falling edge, let one rising edge load, check at next falling edge
    task automatic apply(input int a, input int b, input string req, input int exp);
        @(negedge clk);
        op_a = OP_W'(a);
        op_b = OP_W'(b);
        #1;
        check_vec({req, "/R7"}, wl_cmb, exp);
        @(negedge clk);
        check_vec(req, wl_reg, exp);
    endtask

    initial begin
        int lfsr;
        int a;
        int b;
        int offs [4];
        offs = '{0, 8, 16'h1558, 16'h3FFF};

        // R6: reset holds the registered wordlines at zero
        repeat (3) @(negedge clk);
        checks++;
        if (wl_reg !== '0) begin
            errors++;
            $display("FAIL R6 got_ones=%0d exp_ones=0", $countones(wl_reg));
        end
        rst_n = 1'b1;

        // R1 / R2: sweep every base field against selected offsets
        foreach (offs[k]) begin
            for (int f = 0; f < (1 << (IDX_W + 1)); f++) begin
                a = f << LO_BIT;
                apply(a, offs[k], "R1", exp_row(a, offs[k]));
            end
        end

        // R4: wrap past the top bit
        apply(16'h3FF8, 16'h0008, "R4", 0);
        apply(16'h3FFF, 16'h3FFF, "R4", 1023);
        apply(16'h2000, 16'h2000, "R4", 0);

        // R5: carry generated at bit 3
        apply(16'h0008, 16'h0008, "R5", 1);
        apply(16'h0008, 16'h0000, "R5", 0);
        apply(16'h0018, 16'h0008, "R5", 2);

        // R3: low bits scrambled, row follows only the upper field
        apply(16'h0007, 16'h0007, "R3", 0);
        apply(16'h0017, 16'h0001, "R3", 1);

        // R2 / R3: pseudo-random pairs
        lfsr = 32'h1ACE_5EED;
        for (int n = 0; n < 4096; n++) begin
            lfsr ^= lfsr << 13; lfsr ^= lfsr >>> 17; lfsr ^= lfsr << 5;
            a = lfsr & 16'h3FFF;
            b = (lfsr >>> 14) & 16'h3FFF;
            apply(a, b, "R2", exp_row(a, b));
        end

        // R6: reset asserted again clears the register
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        checks++;
        if (wl_reg !== '0) begin
            errors++;
            $display("FAIL R6 got_ones=%0d exp_ones=0", $countones(wl_reg));
        end

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule